// File: doc/BRIEF.md
# Level-Sensitive Masked Interrupt Controller

This block gathers a parameterised set of level-sensitive interrupt request lines and reduces them to one active-high request towards the processor. Every request line passes through a two-stage synchronizer; the synchronized level is the pending state of that line. There is no latching, so a pending bit clears as soon as its source drops. Software sets a mask word. The output request is raised whenever at least one line is both pending and enabled by the mask.

Software reaches the block through a small synchronous register port with an address, a write strobe with data, and a read strobe with registered read data. The mask word can be read and written. The pending word can only be read. Two further offsets accept writes so that existing driver code still works, but those writes have no effect. Every other offset reads as zero and drops writes.

Top module: `level_intc`

## Requirements
- R1: A pending bit is 1 while its synchronized request line is high and returns to 0 when the line goes low, with no software clear involved.
- R2: `irq_out` is a registered signal equal to the OR of (mask AND pending) from the previous clock, so it changes one clock after a change in the mask or in the pending word.
- R3: The mask word is at byte offset 0x04. A write there replaces the whole mask, and a read there returns it.
- R4: A read at byte offset 0x0C returns the current pending word, bit i for request line i.
- R5: Writes at byte offsets 0x00 and 0x14 change neither the mask nor the output.
- R6: A read at any offset other than 0x04 and 0x0C returns zero. A write at any offset other than 0x00, 0x04 and 0x14 changes nothing. Unaligned offsets count as such other offsets.
- R7: A synchronous active-low reset clears the mask, the pending word and the synchronizer stages, and it drives `irq_out` low.
- R8: A rising request line with its mask bit set raises `irq_out` at the third rising clock edge after the change: two synchronizer stages, then the output register.
- R9: When NUM_IRQ is less than 32, mask and pending bits at NUM_IRQ and above always read as zero, even after a write of all ones.
- R10: Read data is registered. It is valid after the clock edge that samples `rd_en`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | NUM_IRQ | Level-sensitive request lines, may be asynchronous |
| addr | input | ADDR_W | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Active-high interrupt request to the processor |

## Verification
The hardest case to reach from the ports is a request line that drops while it is both masked in and pending. The output must then fall without any software action, which is what shows that nothing latches. The stimulus reaches this by enabling a line, waiting for `irq_out`, and then removing only the line. It also does the reverse: it clears the mask while the line stays high. Random rounds then mix mask and line patterns so that overlap and non-overlap both occur often. Writes of all ones to the inert offsets are made while the output is active.

// File: rtl/intc_pkg.sv
// Package: shared constants for the level-sensitive interrupt controller.
// Assumes byte addressing with 32-bit aligned registers.
package intc_pkg;
    localparam int DATA_W        = 32;
    localparam int OFF_LEVEL_SEL = 'h00;  // accepted, inert
    localparam int OFF_MASK      = 'h04;  // read/write enable mask
    localparam int OFF_PENDING   = 'h0C;  // read-only pending word
    localparam int OFF_CONTROL   = 'h14;  // accepted, inert

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_MASK,
        ACC_INERT,
        ACC_PEND
    } acc_kind_t;
endpackage

// File: rtl/intc_sync.sv
// Module: intc_sync
// Two-flop synchronizer, one chain per request line. The second stage
// is the pending word: it follows the line level with no latching.
// Assumes: inputs may be asynchronous to clk; reset is synchronous active-low.
module intc_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_chain
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one request line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                stab_q <= meta_q;
            end
        end

        assign level_o[g] = stab_q;
    end
endmodule

// File: rtl/intc_regs.sv
// Module: intc_regs
// Register decode, mask storage and registered read mux.
// Assumes: aligned 32-bit accesses only; any other offset is treated as unmapped.
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               rd_en,
    input  logic [NUM_IRQ-1:0] pend_i,
    output logic [NUM_IRQ-1:0] mask_o,
    output logic [DATA_W-1:0]  rdata
);
    acc_kind_t          kind;
    logic [NUM_IRQ-1:0] mask_q;
    logic [DATA_W-1:0]  mask_ext;
    logic [DATA_W-1:0]  pend_ext;
    logic [DATA_W-1:0]  rd_mux;

    // Classify the current address.
    always_comb begin
        if (addr == ADDR_W'(OFF_MASK))
            kind = ACC_MASK;
        else if (addr == ADDR_W'(OFF_PENDING))
            kind = ACC_PEND;
        else if (addr == ADDR_W'(OFF_LEVEL_SEL) || addr == ADDR_W'(OFF_CONTROL))
            kind = ACC_INERT;
        else
            kind = ACC_NONE;
    end

    // Mask storage: only a write at the mask offset changes it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_en && kind == ACC_MASK)
            mask_q <= wdata[NUM_IRQ-1:0];
    end

    // Zero-extend the stored words to the bus width.
    always_comb begin
        mask_ext = '0;
        pend_ext = '0;
        mask_ext[NUM_IRQ-1:0] = mask_q;
        pend_ext[NUM_IRQ-1:0] = pend_i;
    end

    // Select the read value; unmapped and inert offsets return zero.
    always_comb begin
        case (kind)
            ACC_MASK: rd_mux = mask_ext;
            ACC_PEND: rd_mux = pend_ext;
            default:  rd_mux = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    assign mask_o = mask_q;

    // R3: a mask write is stored in full on the next edge
    a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_MASK)) |=> mask_o == $past(wdata[NUM_IRQ-1:0]));

    // R5: inert offsets leave the mask alone
    a_r5_inert_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == ADDR_W'(OFF_LEVEL_SEL) || addr == ADDR_W'(OFF_CONTROL))) |=> $stable(mask_o));

    // R6: reads of unmapped offsets return zero
    a_r6_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != ADDR_W'(OFF_MASK) && addr != ADDR_W'(OFF_PENDING)) |=> rdata == '0);

    // R10: read data holds when no read is strobed
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: rtl/intc_outgen.sv
// Module: intc_outgen
// Registered request output: the OR of enabled pending bits.
// Assumes: mask and pending are both synchronous to clk.
module intc_outgen #(
    parameter int NUM_IRQ = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] mask_i,
    input  logic [NUM_IRQ-1:0] pend_i,
    output logic               irq_o
);
    logic any_active;

    // Reduce the enabled pending bits to one request.
    always_comb any_active = |(mask_i & pend_i);

    // Register the request toward the processor.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= any_active;
    end

    // R2: the output follows the masked pending state one clock later
    a_r2_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == |($past(mask_i & pend_i)));
endmodule

// File: rtl/level_intc.sv
// Module: level_intc (top)
// Level-sensitive masked interrupt controller: synchronizes NUM_IRQ request
// lines into a pending word, gates them with a software mask, and drives
// one registered request.
// Assumes: NUM_IRQ between 1 and 32; aligned 32-bit register accesses.
module level_intc
    import intc_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [31:0]        wdata,
    input  logic               rd_en,
    output logic [31:0]        rdata,
    output logic               irq_out
);
    logic [NUM_IRQ-1:0] pend_w;
    logic [NUM_IRQ-1:0] mask_w;

    intc_sync #(.WIDTH(NUM_IRQ)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_in),
        .level_o (pend_w)
    );

    intc_regs #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .wdata  (wdata),
        .rd_en  (rd_en),
        .pend_i (pend_w),
        .mask_o (mask_w),
        .rdata  (rdata)
    );

    intc_outgen #(.NUM_IRQ(NUM_IRQ)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_i (mask_w),
        .pend_i (pend_w),
        .irq_o  (irq_out)
    );

    // R7: reset clears mask, pending and output
    a_r7_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (irq_out == 1'b0 && mask_w == '0 && pend_w == '0));

    // R1: a pending bit is the input level from two edges earlier
    a_r1_pend_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |=> pend_w == $past(irq_in, 2));
endmodule

// File: tb/tb_level_intc.sv
module tb_level_intc;
    localparam int NIRQ = 24;
    localparam logic [31:0] VMASK = (32'h1 << NIRQ) - 1;

    logic            clk = 0;
    logic            rst_n = 0;
    logic [NIRQ-1:0] irq_in = '0;
    logic [7:0]      addr = '0;
    logic            wr_en = 0;
    logic [31:0]     wdata = '0;
    logic            rd_en = 0;
    logic [31:0]     rdata;
    logic            irq_out;

    int tests = 0;
    int fails = 0;
    logic [31:0] m_mask = '0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    level_intc #(.NUM_IRQ(NIRQ), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .irq_out(irq_out)
    );

    function automatic logic exp_irq(logic [31:0] m, logic [31:0] p);
        return |(m & p & VMASK);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] p;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R7 reset state
        check("R7 irq_out", {31'b0, irq_out}, 0);
        rd(8'h04, rv); check("R7 mask", rv, 0);
        rd(8'h0C, rv); check("R7 pending", rv, 0);

        // R8 latency: mask bit 3, raise line 3 at a negedge
        wr(8'h04, 32'h8); m_mask = 32'h8;
        @(negedge clk); irq_in = 24'h8;
        @(negedge clk); @(negedge clk);
        check("R8 not yet at 2 edges", {31'b0, irq_out}, 0);
        @(negedge clk);
        check("R8 high at 3rd edge", {31'b0, irq_out}, 1);
        rd(8'h0C, rv); check("R4 pending read", rv, 32'h8);
        // R1: drop the line, output falls without software
        irq_in = '0; settle();
        check("R1 pending clears", {31'b0, irq_out}, 0);
        rd(8'h0C, rv); check("R1 pending word", rv, 0);
        // R2: mask removed while line high
        irq_in = 24'h8; settle();
        check("R2 active", {31'b0, irq_out}, 1);
        wr(8'h04, 0); m_mask = 0;
        @(negedge clk);
        check("R2 falls one clock after mask write", {31'b0, irq_out}, 0);
        wr(8'h04, 32'h8); m_mask = 32'h8;
        @(negedge clk);
        check("R2 rises one clock after mask write", {31'b0, irq_out}, 1);
        // R5 inert offsets
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h14, 32'h0);
        rd(8'h04, rv); check("R5 mask unchanged", rv, 32'h8);
        check("R5 output unchanged", {31'b0, irq_out}, 1);
        // R6 unmapped writes and reads
        wr(8'h08, 32'h0); wr(8'h05, 32'h0); wr(8'h10, 32'hFFFF);
        rd(8'h04, rv); check("R6 mask unchanged", rv, 32'h8);
        rd(8'h00, rv); check("R6 read 0x00", rv, 0);
        rd(8'h14, rv); check("R6 read 0x14", rv, 0);
        rd(8'h0D, rv); check("R6 unaligned read", rv, 0);
        // R9 upper bits
        wr(8'h04, 32'hFFFF_FFFF); m_mask = VMASK;
        rd(8'h04, rv); check("R9 mask upper zero", rv, VMASK);
        irq_in = '1; settle();
        rd(8'h0C, rv); check("R9 pending upper zero", rv, VMASK);
        // R10 hold
        rd(8'h04, rv);
        repeat (3) @(negedge clk);
        check("R10 rdata holds", rdata, VMASK);
        // R3 random mask write/read and R2 random output
        for (int i = 0; i < 200; i++) begin
            logic [31:0] mw;
            mw = $urandom();
            p = $urandom() & ((i % 3 == 0) ? 32'h0000_000F : 32'hFFFF_FFFF);
            if (i % 4 == 0) mw = mw & ~p;
            wr(8'h04, mw); m_mask = mw & VMASK;
            irq_in = p[NIRQ-1:0];
            settle();
            rd(8'h04, rv); check("R3 mask readback", rv, m_mask);
            rd(8'h0C, rv); check("R4 pending random", rv, p & VMASK);
            check("R2 random output", {31'b0, irq_out}, {31'b0, exp_irq(m_mask, p)});
        end
        // R7 reset again with active output
        wr(8'h04, VMASK); irq_in = '1; settle();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1; irq_in = '0;
        check("R7 irq after reset", {31'b0, irq_out}, 0);
        rd(8'h04, rv); check("R7 mask after reset", rv, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule